// File: doc/BRIEF.md
# Host management register port

This block is the slave side of an 8-bit host bus with a 4-bit address. The host moves 32-bit command and payload words to and from an internal processor by single-byte accesses, with the most significant byte first. An access is framed by an enable strobe and a data strobe, which are both active low, and a read/write line that is high for reads. A write takes effect when the access ends. Accesses to the least significant byte of a word are special. Writing that byte hands the complete word to the processor side with a one-cycle valid pulse. Reading that byte asks the processor side for its next word with a one-cycle fetch pulse.

Two active-low lines go back to the host:
- The attention line latches any event whose bit is set in a host-written enable mask. It releases only when the host sends the acknowledge command.
- The request line means "data ready" (low) in read mode and "room available" (high) in write mode. The mode follows the opcode byte of the last command word the host wrote.

A control register holds the event mask. A status register reflects both lines and the current mode.

Top module: `hmp_port`

## Requirements
- R1: After reset the attention line is high, the mode is read, the control register reads 0x00, and no valid or fetch pulse is present.
- R2: An access is active only while both strobes are low. A write changes nothing while the access is still active. It takes effect on the first clock at which either strobe is sampled high.
- R3: Addresses 0–3 are command bytes and addresses 4–7 are payload bytes. Within each group the lowest address is the most significant byte (bits 31:24). Writing address 3 (or 7) drives the assembled word on the command (or payload) word output, with a valid pulse one cycle long.
- R4: While a read access is active, the output enable is high. Addresses 0–3 return the bytes of the processor's reply word, most significant first. Addresses 4–7 return the bytes of its outbound payload word. The output enable is low at all other times.
- R5: The end of a read access to address 3 (or 7) gives exactly one reply-fetch (or payload-fetch) pulse, one cycle long.
- R6: Address 8 is a read/write control register that holds the 8-bit event mask.
- R7: The attention line goes low on the clock after an event bit is seen that is also set in the mask. Events whose mask bit is clear are ignored. The line stays low until a command word whose opcode byte is 0x02 is committed.
- R8: The opcode byte (bits 31:24 of a committed command word) sets the mode:
  - 0x01, 0x10, 0x12 and 0x14 select read mode.
  - 0x11 and 0x13 select write mode.
  - Every other code leaves the mode as it was.
- R9: In read mode the request line is the inverse of the processor's "data ready" input. In write mode it equals the "room available" input.
- R10: Address 9 reads as status, and writes to it are ignored:
  - bit 0 is the request line;
  - bit 1 is the attention line;
  - bit 2 is 1 in read mode;
  - the other bits are 0.
- R11: Addresses 10–15 read as 0x00, and writes to them change no register.
- R12: If a masked event arrives in the same cycle as the acknowledge command commits, the attention line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_en_n | input | 1 | Host enable strobe, active low |
| host_ds_n | input | 1 | Host data strobe, active low |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | DATA_W | Write data from host |
| host_rdata | output | DATA_W | Read data to host |
| host_rdata_oe | output | 1 | Read data drive enable |
| host_ack_n | output | 1 | Attention line, active low |
| host_req_n | output | 1 | Request line |
| core_cmd_word | output | WORD_BYTES*DATA_W | Assembled command word |
| core_cmd_valid | output | 1 | Command word committed pulse |
| core_dat_word | output | WORD_BYTES*DATA_W | Assembled payload word |
| core_dat_valid | output | 1 | Payload word committed pulse |
| core_rmsg_word | input | WORD_BYTES*DATA_W | Reply word offered to host |
| core_rmsg_fetch | output | 1 | Reply word consumed pulse |
| core_rdat_word | input | WORD_BYTES*DATA_W | Outbound payload word offered to host |
| core_rdat_fetch | output | 1 | Payload word consumed pulse |
| core_event | input | DATA_W | Event bits, level sampled each clock |
| core_rd_avail | input | 1 | Processor has data for the host |
| core_wr_space | input | 1 | Processor has room for host data |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, 4-bit address, 4-byte words and a two-stage reset synchronizer. With these values all 16 addresses can be reached, including the six unused ones and the status and control registers. The opcode table is walked in an order that toggles the mode and that also inserts codes with no effect on it. Strobe release is varied between the two strobes, and one write is held active for several cycles, so that the commit point is observed. The mask and the event pattern are chosen so that one event is masked, one is allowed, and one arrives in the same cycle as the acknowledge command.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

  localparam logic [7:0] OP_IDENT   = 8'h01;
  localparam logic [7:0] OP_ACK     = 8'h02;
  localparam logic [7:0] OP_XLT_RD  = 8'h10;
  localparam logic [7:0] OP_XLT_WR  = 8'h11;
  localparam logic [7:0] OP_PKT_RD  = 8'h12;
  localparam logic [7:0] OP_PKT_WR  = 8'h13;
  localparam logic [7:0] OP_COUNTS  = 8'h14;

  typedef enum logic [1:0] {
    MODE_KEEP   = 2'd0,
    MODE_TO_RD  = 2'd1,
    MODE_TO_WR  = 2'd2
  } mode_req_e;

  function automatic mode_req_e decode_op(input logic [7:0] op);
    mode_req_e r;
    case (op)
      OP_IDENT, OP_XLT_RD, OP_PKT_RD, OP_COUNTS: r = MODE_TO_RD;
      OP_XLT_WR, OP_PKT_WR:                      r = MODE_TO_WR;
      default:                                   r = MODE_KEEP;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hmp_bus_front.sv
module hmp_bus_front #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              ds_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              act,
  output logic              done_wr,
  output logic              done_rd,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);

  logic              act_q, act_d;
  logic              lrw_q, lrw_d;
  logic [ADDR_W-1:0] laddr_q, laddr_d;
  logic [DATA_W-1:0] ldata_q, ldata_d;
  logic              done;

  assign act  = ~en_n & ~ds_n;
  assign done = act_q & ~act;

  always_comb begin
    act_d   = act;
    lrw_d   = lrw_q;
    laddr_d = laddr_q;
    ldata_d = ldata_q;
    if (act) begin
      lrw_d   = rw;
      laddr_d = addr;
      ldata_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      lrw_q   <= 1'b1;
      laddr_q <= '0;
      ldata_q <= '0;
    end else begin
      act_q   <= act_d;
      lrw_q   <= lrw_d;
      laddr_q <= laddr_d;
      ldata_q <= ldata_d;
    end
  end

  assign done_wr = done & ~lrw_q;
  assign done_rd = done & lrw_q;
  assign op_addr = laddr_q;
  assign op_data = ldata_q;

endmodule

// File: rtl/hmp_word_regs.sv
module hmp_word_regs #(
  parameter int DATA_W     = 8,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
  localparam int WORD_W    = WORD_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [WORD_W-1:0] word,
  output logic              commit
);

  logic commit_q, commit_d;

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    logic [DATA_W-1:0] lane_q, lane_d;
    logic              lane_en;

    assign lane_en = wr_en && (wr_idx == IDX_W'(b));

    always_comb begin
      lane_d = lane_q;
      if (lane_en) lane_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign word[(WORD_BYTES-1-b)*DATA_W +: DATA_W] = lane_q;
  end

  assign commit_d = wr_en && (wr_idx == IDX_W'(WORD_BYTES-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commit_q <= 1'b0;
    else        commit_q <= commit_d;
  end

  assign commit = commit_q;

endmodule

// File: rtl/hmp_mode_ctl.sv
module hmp_mode_ctl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic [7:0]        op_code,
  input  logic [DATA_W-1:0] event_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              rd_avail_i,
  input  logic              wr_space_i,
  output logic              ack_n,
  output logic              req_n,
  output logic              mode_rd
);
  import hmp_pkg::*;

  logic      mode_q, mode_d;
  logic      ack_q, ack_d;
  logic      ev_hit, ack_clr;
  mode_req_e mreq;

  assign mreq    = decode_op(op_code);
  assign ev_hit  = |(event_i & mask_i);
  assign ack_clr = cmd_go && (op_code == OP_ACK);

  always_comb begin
    mode_d = mode_q;
    if (cmd_go) begin
      case (mreq)
        MODE_TO_RD: mode_d = 1'b1;
        MODE_TO_WR: mode_d = 1'b0;
        default:    mode_d = mode_q;
      endcase
    end
    ack_d = ev_hit | (ack_q & ~ack_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
      ack_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ack_q  <= ack_d;
    end
  end

  assign mode_rd = mode_q;
  assign ack_n   = ~ack_q;
  assign req_n   = mode_q ? ~rd_avail_i : wr_space_i;

endmodule

// File: rtl/hmp_port.sv
module hmp_port #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int WORD_BYTES  = 4,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = WORD_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en_n,
  input  logic              host_ds_n,
  input  logic              host_rw,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdata_oe,
  output logic              host_ack_n,
  output logic              host_req_n,
  output logic [WORD_W-1:0] core_cmd_word,
  output logic              core_cmd_valid,
  output logic [WORD_W-1:0] core_dat_word,
  output logic              core_dat_valid,
  input  logic [WORD_W-1:0] core_rmsg_word,
  output logic              core_rmsg_fetch,
  input  logic [WORD_W-1:0] core_rdat_word,
  output logic              core_rdat_fetch,
  input  logic [DATA_W-1:0] core_event,
  input  logic              core_rd_avail,
  input  logic              core_wr_space
);

  localparam int IDX_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam logic [ADDR_W-1:0] A_DAT0 = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(2*WORD_BYTES);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(2*WORD_BYTES + 1);
  localparam logic [ADDR_W-1:0] A_MSGD = ADDR_W'(WORD_BYTES - 1);
  localparam logic [ADDR_W-1:0] A_DATD = ADDR_W'(2*WORD_BYTES - 1);

  // reset: asserted at once, released through a flop chain
  logic rst_s;
  if (SYNC_STAGES <= 1) begin : g_rs1
    logic rs_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rs_q <= 1'b0;
      else        rs_q <= 1'b1;
    end
    assign rst_s = rs_q;
  end else begin : g_rsn
    logic [SYNC_STAGES-1:0] rs_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rs_q <= '0;
      else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
    end
    assign rst_s = rs_q[SYNC_STAGES-1];
  end

  logic              act, done_wr, done_rd;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;

  hmp_bus_front #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_front (
    .clk(clk), .rst_n(rst_s),
    .en_n(host_en_n), .ds_n(host_ds_n), .rw(host_rw),
    .addr(host_addr), .wdata(host_wdata),
    .act(act), .done_wr(done_wr), .done_rd(done_rd),
    .op_addr(op_addr), .op_data(op_data)
  );

  logic msg_hit, dat_hit, cmd_go;
  assign msg_hit = done_wr && (op_addr <  A_DAT0);
  assign dat_hit = done_wr && (op_addr >= A_DAT0) && (op_addr < A_CTL);
  assign cmd_go  = done_wr && (op_addr == A_MSGD);

  hmp_word_regs #(.DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)) u_cmd (
    .clk(clk), .rst_n(rst_s), .wr_en(msg_hit),
    .wr_idx(op_addr[IDX_W-1:0]), .wr_data(op_data),
    .word(core_cmd_word), .commit(core_cmd_valid)
  );

  hmp_word_regs #(.DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)) u_dat (
    .clk(clk), .rst_n(rst_s), .wr_en(dat_hit),
    .wr_idx(op_addr[IDX_W-1:0]), .wr_data(op_data),
    .word(core_dat_word), .commit(core_dat_valid)
  );

  // control register: event mask
  logic [DATA_W-1:0] ctl_q, ctl_d;
  always_comb begin
    ctl_d = ctl_q;
    if (done_wr && (op_addr == A_CTL)) ctl_d = op_data;
  end

  // fetch pulses at the end of a least-significant-byte read
  logic mf_q, mf_d, df_q, df_d;
  assign mf_d = done_rd && (op_addr == A_MSGD);
  assign df_d = done_rd && (op_addr == A_DATD);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctl_q <= '0;
      mf_q  <= 1'b0;
      df_q  <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      mf_q  <= mf_d;
      df_q  <= df_d;
    end
  end

  assign core_rmsg_fetch = mf_q;
  assign core_rdat_fetch = df_q;

  logic mode_rd;

  hmp_mode_ctl #(.DATA_W(DATA_W)) u_mode (
    .clk(clk), .rst_n(rst_s), .cmd_go(cmd_go),
    .op_code(core_cmd_word[WORD_W-1 -: 8]),
    .event_i(core_event), .mask_i(ctl_q),
    .rd_avail_i(core_rd_avail), .wr_space_i(core_wr_space),
    .ack_n(host_ack_n), .req_n(host_req_n), .mode_rd(mode_rd)
  );

  // read path
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] sts_v;
  assign rd_idx = host_addr[IDX_W-1:0];

  always_comb begin
    sts_v    = '0;
    sts_v[0] = host_req_n;
    sts_v[1] = host_ack_n;
    sts_v[2] = mode_rd;
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr < A_DAT0)
      host_rdata = core_rmsg_word[(WORD_BYTES-1-int'(rd_idx))*DATA_W +: DATA_W];
    else if (host_addr < A_CTL)
      host_rdata = core_rdat_word[(WORD_BYTES-1-int'(rd_idx))*DATA_W +: DATA_W];
    else if (host_addr == A_CTL)
      host_rdata = ctl_q;
    else if (host_addr == A_STS)
      host_rdata = sts_v;
  end

  assign host_rdata_oe = act & host_rw;

endmodule

// File: rtl/hmp_port_chk.sv
module hmp_port_chk #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = WORD_BYTES * DATA_W
) (
  input logic              clk,
  input logic              rst_s,
  input logic              host_en_n,
  input logic              host_ds_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_rdata_oe,
  input logic              host_ack_n,
  input logic              host_req_n,
  input logic [WORD_W-1:0] core_cmd_word,
  input logic              core_cmd_valid,
  input logic              core_dat_valid,
  input logic              core_rdat_fetch
);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(2*WORD_BYTES + 1);

  assert_write_on_release_R2: assert property (@(posedge clk) disable iff (!rst_s)
    core_dat_valid |-> ($past(!host_en_n && !host_ds_n, 2) && !$past(!host_en_n && !host_ds_n)));

  assert_cmd_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_s)
    core_cmd_valid |=> !core_cmd_valid);

  assert_fetch_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_s)
    core_rdat_fetch |=> !core_rdat_fetch);

  assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(host_ack_n) |-> (core_cmd_valid && core_cmd_word[WORD_W-1 -: 8] == 8'h02));

  assert_status_lines_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (host_rdata_oe && host_addr == A_STS) |-> (host_rdata[1:0] == {host_ack_n, host_req_n}));

  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_s)
    (host_rdata_oe && host_addr > A_STS) |-> (host_rdata == '0));

endmodule

bind hmp_port hmp_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) i_chk (
  .clk(clk), .rst_s(rst_s),
  .host_en_n(host_en_n), .host_ds_n(host_ds_n), .host_addr(host_addr),
  .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
  .host_ack_n(host_ack_n), .host_req_n(host_req_n),
  .core_cmd_word(core_cmd_word), .core_cmd_valid(core_cmd_valid),
  .core_dat_valid(core_dat_valid), .core_rdat_fetch(core_rdat_fetch)
);

// File: tb/test_hmp_port.sv
module test_hmp_port;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_en_n, host_ds_n, host_rw;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata, host_rdata;
  logic          host_rdata_oe, host_ack_n, host_req_n;
  logic [WW-1:0] core_cmd_word, core_dat_word, core_rmsg_word, core_rdat_word;
  logic          core_cmd_valid, core_dat_valid, core_rmsg_fetch, core_rdat_fetch;
  logic [DW-1:0] core_event;
  logic          core_rd_avail, core_wr_space;

  hmp_port i_hmp_port (
    .clk(clk), .rst_n(rst_n),
    .host_en_n(host_en_n), .host_ds_n(host_ds_n), .host_rw(host_rw),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
    .host_ack_n(host_ack_n), .host_req_n(host_req_n),
    .core_cmd_word(core_cmd_word), .core_cmd_valid(core_cmd_valid),
    .core_dat_word(core_dat_word), .core_dat_valid(core_dat_valid),
    .core_rmsg_word(core_rmsg_word), .core_rmsg_fetch(core_rmsg_fetch),
    .core_rdat_word(core_rdat_word), .core_rdat_fetch(core_rdat_fetch),
    .core_event(core_event), .core_rd_avail(core_rd_avail),
    .core_wr_space(core_wr_space)
  );

  always #10 clk = ~clk;  // 50 MHz

  int total = 0;
  int bad   = 0;
  bit fin   = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int         m_sc = 0;
  bit         m_live = 1'b0;
  logic       m_actq, m_lrw, m_ack, m_rd, m_cv, m_dv, m_mf, m_df;
  logic [3:0] m_laddr;
  logic [7:0] m_ldata, m_ctl;
  logic [7:0] m_msg[4];
  logic [7:0] m_dat[4];
  logic       m_act, m_done, m_wr, m_rdn, m_ev, m_clr;

  task automatic model_reset();
    m_actq = 0; m_lrw = 1; m_laddr = 0; m_ldata = 0; m_ctl = 0;
    m_ack = 0; m_rd = 1; m_cv = 0; m_dv = 0; m_mf = 0; m_df = 0;
    for (int i = 0; i < 4; i++) begin m_msg[i] = 0; m_dat[i] = 0; end
  endtask

  always @(posedge clk) begin
    m_live = 1'b1;
    if (!rst_n) begin
      model_reset();
      m_sc = 0;
    end else if (m_sc < 2) begin
      model_reset();
      m_sc++;
    end else begin
      m_act  = !host_en_n && !host_ds_n;
      m_done = m_actq && !m_act;
      m_wr   = m_done && !m_lrw;
      m_rdn  = m_done && m_lrw;
      m_ev   = |(core_event & m_ctl);
      m_clr  = m_wr && m_laddr == 3 && m_msg[0] == 8'h02;
      if (m_wr && m_laddr == 3) begin
        if (m_msg[0] inside {8'h01, 8'h10, 8'h12, 8'h14}) m_rd = 1;
        else if (m_msg[0] inside {8'h11, 8'h13})          m_rd = 0;
      end
      m_ack = m_ev | (m_ack & !m_clr);
      m_cv  = m_wr && m_laddr == 3;
      m_dv  = m_wr && m_laddr == 7;
      m_mf  = m_rdn && m_laddr == 3;
      m_df  = m_rdn && m_laddr == 7;
      if (m_wr) begin
        if (m_laddr < 4)       m_msg[m_laddr]     = m_ldata;
        else if (m_laddr < 8)  m_dat[m_laddr - 4] = m_ldata;
        else if (m_laddr == 8) m_ctl              = m_ldata;
      end
      m_actq = m_act;
      if (m_act) begin
        m_laddr = host_addr; m_lrw = host_rw; m_ldata = host_wdata;
      end
    end
  end

  function automatic logic [7:0] exp_rdata(input logic [3:0] a);
    logic req;
    req = m_rd ? !core_rd_avail : core_wr_space;
    if (a < 4)       return 8'(core_rmsg_word >> (8*(3 - a)));
    else if (a < 8)  return 8'(core_rdat_word >> (8*(7 - a)));
    else if (a == 8) return m_ctl;
    else if (a == 9) return {5'b0, m_rd, !m_ack, req};
    else             return 8'h00;
  endfunction

  always @(negedge clk) begin
    if (m_live && !fin) begin
      logic oe;
      oe = !host_en_n && !host_ds_n && host_rw;
      chk("R7 ack line", {31'b0, host_ack_n}, {31'b0, !m_ack});
      chk("R9 request line", {31'b0, host_req_n},
          {31'b0, m_rd ? !core_rd_avail : core_wr_space});
      chk("R3 cmd valid", {31'b0, core_cmd_valid}, {31'b0, m_cv});
      chk("R3 dat valid", {31'b0, core_dat_valid}, {31'b0, m_dv});
      chk("R3 cmd word", core_cmd_word, {m_msg[0], m_msg[1], m_msg[2], m_msg[3]});
      chk("R3 dat word", core_dat_word, {m_dat[0], m_dat[1], m_dat[2], m_dat[3]});
      chk("R5 reply fetch", {31'b0, core_rmsg_fetch}, {31'b0, m_mf});
      chk("R5 payload fetch", {31'b0, core_rdat_fetch}, {31'b0, m_df});
      chk("R4 output enable", {31'b0, host_rdata_oe}, {31'b0, oe});
      if (oe) chk("R4 read data", {24'b0, host_rdata}, {24'b0, exp_rdata(host_addr)});
    end
  end

  // ---------------- host bus tasks ----------------
  task automatic bus_write(input logic [3:0] a, input logic [7:0] d, input bit rel_en);
    @(posedge clk); #2;
    host_addr = a; host_wdata = d; host_rw = 0; host_en_n = 0; host_ds_n = 0;
    @(posedge clk); #2;
    if (rel_en) host_en_n = 1; else host_ds_n = 1;
    @(posedge clk); #2;
    host_en_n = 1; host_ds_n = 1; host_rw = 1;
  endtask

  task automatic bus_read(input logic [3:0] a, input bit rel_en, output logic [7:0] v);
    @(posedge clk); #2;
    host_addr = a; host_rw = 1; host_en_n = 0; host_ds_n = 0;
    @(negedge clk);
    v = host_rdata;
    @(posedge clk); #2;
    if (rel_en) host_en_n = 1; else host_ds_n = 1;
    @(posedge clk); #2;
    host_en_n = 1; host_ds_n = 1;
  endtask

  task automatic send_cmd(input logic [7:0] op);
    bus_write(4'd0, op, 0);
    bus_write(4'd1, 8'h00, 1);
    bus_write(4'd2, 8'h00, 0);
    bus_write(4'd3, 8'h5A, 1);
  endtask

  task automatic pulse_event(input logic [7:0] e);
    @(posedge clk); #2; core_event = e;
    @(posedge clk); #2; core_event = 8'h00;
    @(posedge clk); #2;
  endtask

  function automatic bit next_mode(input logic [7:0] op, input bit cur);
    case (op)
      8'h01, 8'h10, 8'h12, 8'h14: return 1'b1;
      8'h11, 8'h13:               return 1'b0;
      default:                    return cur;
    endcase
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] v;
    logic [7:0] codes[10];
    bit         emode;
    codes = '{8'h11, 8'h05, 8'h14, 8'h13, 8'h01, 8'h12, 8'h10, 8'h02, 8'h11, 8'h00};

    rst_n = 0; host_en_n = 1; host_ds_n = 1; host_rw = 1;
    host_addr = 0; host_wdata = 0; core_event = 0;
    core_rd_avail = 0; core_wr_space = 0;
    core_rmsg_word = 32'hA1B2C3D4; core_rdat_word = 32'h11223344;
    repeat (3) @(posedge clk);
    #5;
    chk("R1 ack high in reset", {31'b0, host_ack_n}, 32'd1);
    chk("R1 no cmd valid in reset", {31'b0, core_cmd_valid}, 32'd0);
    #2; rst_n = 1;
    repeat (4) @(posedge clk);

    bus_read(4'd9, 0, v);  chk("R1 R10 status after reset", {24'b0, v}, 32'h07);
    bus_read(4'd8, 1, v);  chk("R1 control after reset", {24'b0, v}, 32'h00);
    bus_write(4'd8, 8'h05, 1);
    bus_read(4'd8, 0, v);  chk("R6 control readback", {24'b0, v}, 32'h05);

    bus_write(4'd4, 8'hDE, 0);
    bus_write(4'd5, 8'hAD, 1);
    bus_write(4'd6, 8'hBE, 0);
    bus_write(4'd7, 8'hEF, 1);
    chk("R3 payload word big-endian", core_dat_word, 32'hDEADBEEF);

    // R2: a long write has no effect until a strobe rises
    @(posedge clk); #2;
    host_addr = 4'd4; host_wdata = 8'h77; host_rw = 0; host_en_n = 0; host_ds_n = 0;
    repeat (3) begin
      @(posedge clk); #2;
      chk("R2 no change while active", core_dat_word, 32'hDEADBEEF);
    end
    host_en_n = 1;
    @(posedge clk); #2;
    chk("R2 write after strobe release", core_dat_word, 32'h77ADBEEF);
    host_ds_n = 1; host_rw = 1;

    bus_read(4'd4, 0, v); chk("R4 payload byte A", {24'b0, v}, 32'h11);
    bus_read(4'd5, 1, v); chk("R4 payload byte B", {24'b0, v}, 32'h22);
    bus_read(4'd6, 0, v); chk("R4 payload byte C", {24'b0, v}, 32'h33);
    bus_read(4'd7, 1, v); chk("R4 R5 payload byte D", {24'b0, v}, 32'h44);
    core_rdat_word = 32'h55667788;
    bus_read(4'd0, 0, v); chk("R4 reply byte A", {24'b0, v}, 32'hA1);
    bus_read(4'd3, 0, v); chk("R4 R5 reply byte D", {24'b0, v}, 32'hD4);
    bus_read(4'd7, 0, v); chk("R4 new payload byte D", {24'b0, v}, 32'h88);

    // R8 mode walk
    emode = 1'b1;
    foreach (codes[i]) begin
      send_cmd(codes[i]);
      emode = next_mode(codes[i], emode);
      bus_read(4'd9, 0, v);
      chk("R8 mode bit", {31'b0, v[2]}, {31'b0, emode});
    end

    // R9 request line in both modes (mode is currently write)
    core_wr_space = 1; @(posedge clk); #2;
    chk("R9 write mode room", {31'b0, host_req_n}, 32'd1);
    core_wr_space = 0; @(posedge clk); #2;
    chk("R9 write mode no room", {31'b0, host_req_n}, 32'd0);
    send_cmd(8'h01);
    core_rd_avail = 1; @(posedge clk); #2;
    chk("R9 read mode data ready", {31'b0, host_req_n}, 32'd0);
    bus_read(4'd9, 1, v); chk("R10 status request bit", {24'b0, v}, 32'h06);
    core_rd_avail = 0;

    // R7 masked and unmasked events (mask 0x05)
    pulse_event(8'h02);
    chk("R7 masked event ignored", {31'b0, host_ack_n}, 32'd1);
    pulse_event(8'h04);
    chk("R7 event asserts ack", {31'b0, host_ack_n}, 32'd0);
    repeat (3) @(posedge clk); #2;
    chk("R7 ack held", {31'b0, host_ack_n}, 32'd0);
    send_cmd(8'h02);
    chk("R7 ack cleared by command", {31'b0, host_ack_n}, 32'd1);

    // R12 event coincident with the acknowledge command
    @(posedge clk); #2; core_event = 8'h01;
    send_cmd(8'h02);
    chk("R12 ack kept with live event", {31'b0, host_ack_n}, 32'd0);
    core_event = 8'h00;
    send_cmd(8'h02);
    chk("R12 ack cleared after event", {31'b0, host_ack_n}, 32'd1);

    // R10 and R11 ignored writes
    bus_write(4'd9, 8'hFF, 0);
    bus_read(4'd9, 0, v); chk("R10 status write ignored", {24'b0, v}, 32'h07);
    for (int a = 10; a < 16; a++) bus_write(4'(a), 8'hFF, a[0]);
    for (int a = 10; a < 16; a++) begin
      bus_read(4'(a), 0, v);
      chk("R11 unused reads zero", {24'b0, v}, 32'h00);
    end
    bus_read(4'd8, 0, v); chk("R11 control untouched", {24'b0, v}, 32'h05);
    chk("R11 payload untouched", core_dat_word, 32'h77ADBEEF);
    chk("R11 command untouched", core_cmd_word, 32'h0200005A);

    repeat (3) @(posedge clk);
    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule